// File: doc/BRIEF.md
# HDMI Lane Period Encoder

This block turns the per-pixel inputs of one HDMI TMDS lane into the 10-bit line symbol for that lane, one symbol per pixel clock. Two enables choose the link period. With the video enable high, the pixel byte is TMDS-coded with running-disparity DC balance. With only the auxiliary enable high, the cycle belongs to a data island and the 4-bit nibble is TERC4-coded. With both enables low, the cycle is a control period and the two control bits select one of four control symbols. The block inserts guard-band symbols at the edges of video and island periods on its own.

A preamble guard has to start before video begins. To place it, the block delays every input by `GUARD_LEN` stages and looks at the newer stages. Upstream logic therefore only drives the enables with the timing of the payload and never announces a boundary in advance. If the auxiliary enable is never raised, the lane acts as a DVI lane driven by a single data enable. Three instances, with `CHANNEL` set to 0, 1 and 2, make up a full link.

Top module: `hdmi_lane_encoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the symbol becomes 1101010100 and the running disparity returns to zero, whatever the other inputs are.
- R2: A control cycle that is not a preamble guard emits a code chosen by `ctl` (bit 1 first): 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011.
- R3: A video cycle emits the TMDS code of `pix`. A sink can decode it back to `pix`: invert bits 7:0 when bit 9 is set; then bit 0 is data bit 0, and each data bit i≥1 is bit i XOR bit i−1 when bit 8 is 1, or XNOR when bit 8 is 0. The choice between XOR and XNOR minimises transitions, and the bit-9 inversion follows the running disparity.
- R4: Every cycle that is not a video cycle clears the running disparity, so the first video cycle after any blanking is coded from a disparity of zero.
- R5: When the next video cycle is at most two cycles ahead and all the cycles between are control cycles, each such control cycle emits a preamble guard: 0100110011 on channel 1 and 1011001100 on channels 0 and 2.
- R6: An island cycle that lies within two cycles of either end of its island emits a guard: 0100110011 on channels 1 and 2. On channel 0 it is the TERC4 code of {1,1,ctl[1],ctl[0]}. An island of four cycles or fewer is therefore all guard.
- R7: Every other island cycle emits the TERC4 code of `nib`. The codes for nib 0 to 15 are: 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011.
- R8: If both enables are high, the cycle is treated as a video cycle.
- R9: A value captured at a rising edge shows up on `sym` right after the second rising edge that follows the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_en | input | 1 | Video period enable |
| aux_en | input | 1 | Data-island period enable |
| pix | input | 8 | Pixel byte for this lane |
| nib | input | 4 | Island nibble for this lane |
| ctl | input | 2 | Control bits (on lane 0: bit 1 vertical sync, bit 0 horizontal sync) |
| sym | output | 10 | TMDS line symbol |

## Verification
If the disparity state is wrong, a later video symbol has a flipped bit 9 and inverted data bits compared with a fresh model. This shows at once if the error is in the first video cycle after blanking, and otherwise within a few cycles as the run goes on. If the lookahead or island history is wrong, a guard comes out one cycle early or late, or a payload code takes the place of a guard. Both are visible at the port two cycles after the boundary input. Streams that change period every few cycles pin down each boundary on both channel variants.

// File: rtl/hdmi_lane_pkg.sv
// Shared widths, the beat record, period kinds and fixed code tables
// for the HDMI lane encoder. Assumes a 10-bit symbol built from an
// 8-bit pixel.
package hdmi_lane_pkg;

    localparam int BYTE_W = 8;
    localparam int SYM_W  = BYTE_W + 2;
    localparam int NIB_W  = 4;
    localparam int CTL_W  = 2;

    // One input beat after priority resolution
    typedef struct packed {
        logic               vid;
        logic               isl;
        logic [BYTE_W-1:0]  pix;
        logic [NIB_W-1:0]   nib;
        logic [CTL_W-1:0]   ctl;
    } lane_beat_t;

    // What the current beat is to be coded as
    typedef enum logic [2:0] {
        K_CTRL   = 3'd0,
        K_VGUARD = 3'd1,
        K_VIDEO  = 3'd2,
        K_IGUARD = 3'd3,
        K_IPAY   = 3'd4
    } lane_kind_e;

    localparam logic [SYM_W-1:0] GUARD_A = 10'b1011001100;
    localparam logic [SYM_W-1:0] GUARD_B = 10'b0100110011;

    localparam logic [SYM_W-1:0] TERC4_LUT [16] = '{
        10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
        10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
        10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
        10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011
    };

    localparam logic [SYM_W-1:0] CTRL_LUT [4] = '{
        10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011
    };

    function automatic logic [SYM_W-1:0] terc4_code(input logic [NIB_W-1:0] n);
        return TERC4_LUT[n];
    endfunction

    function automatic logic [SYM_W-1:0] ctrl_code(input logic [CTL_W-1:0] c);
        return CTRL_LUT[c];
    endfunction

endpackage

// File: rtl/lane_period_tracker.sv
// Delays input beats by GUARD_LEN stages and classifies the oldest one,
// using the newer stages as lookahead and a short history of island flags.
// Assumes beats arrive with priority already resolved (isl implies !vid).
module lane_period_tracker
    import hdmi_lane_pkg::*;
#(
    parameter int GUARD_LEN = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  lane_beat_t  beat_in,
    output lane_beat_t  beat_cur,
    output lane_kind_e  kind
);

    lane_beat_t             pipe [GUARD_LEN];
    lane_beat_t             fut  [GUARD_LEN+1];
    logic [GUARD_LEN-1:0]   isl_hist;

    // Purpose: shift the lookahead delay line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < GUARD_LEN; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= beat_in;
            for (int k = 1; k < GUARD_LEN; k++) pipe[k] <= pipe[k-1];
        end
    end

    // fut[0] is the beat being coded, fut[k] the beat k cycles later
    for (genvar k = 0; k <= GUARD_LEN; k++) begin : g_fut
        if (k == GUARD_LEN) begin : g_live
            assign fut[k] = beat_in;
        end else begin : g_reg
            assign fut[k] = pipe[GUARD_LEN-1-k];
        end
    end

    assign beat_cur = fut[0];

    // Purpose: remember whether the last GUARD_LEN coded beats were island
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isl_hist <= '0;
        end else begin
            isl_hist[0] <= fut[0].isl;
            for (int k = 1; k < GUARD_LEN; k++) isl_hist[k] <= isl_hist[k-1];
        end
    end

    // Purpose: decide the period kind of the current beat
    always_comb begin
        logic near_edge;
        logic quiet;
        logic vid_soon;
        near_edge = 1'b0;
        quiet     = 1'b1;
        vid_soon  = 1'b0;
        for (int k = 1; k <= GUARD_LEN; k++) begin
            if (!fut[k].isl || !isl_hist[k-1]) near_edge = 1'b1;
            if (quiet && fut[k].vid) vid_soon = 1'b1;
            quiet = quiet && !fut[k].vid && !fut[k].isl;
        end
        if (fut[0].vid)       kind = K_VIDEO;
        else if (fut[0].isl)  kind = near_edge ? K_IGUARD : K_IPAY;
        else                  kind = vid_soon ? K_VGUARD : K_CTRL;
    end

    // R6
    // An island never starts with a payload beat
    isl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != K_IPAY && kind != K_IGUARD) |=> (kind != K_IPAY));

    // R6
    // An island never ends straight after a payload beat
    isl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_IPAY) |=> (kind == K_IPAY || kind == K_IGUARD));

    // R5
    // A preamble guard leads only to more guard or to video
    vid_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_VGUARD) |=> (kind == K_VGUARD || kind == K_VIDEO));

endmodule

// File: rtl/tmds_video_path.sv
// TMDS coding of one pixel byte: transition-minimising XOR/XNOR chain
// followed by running-disparity DC balance. The disparity counter advances
// on video beats and is cleared on every other beat.
module tmds_video_path
    import hdmi_lane_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic [BYTE_W-1:0]   pix,
    output logic [SYM_W-1:0]    sym
);

    localparam int DISP_W = $clog2(BYTE_W) + 3;

    logic signed [DISP_W-1:0]   disp;
    logic signed [DISP_W-1:0]   disp_nxt;
    logic [BYTE_W:0]            qm;

    // Purpose: build the transition-minimised intermediate word
    always_comb begin
        int  ones_in;
        logic use_xnor;
        ones_in  = $countones(pix);
        use_xnor = (ones_in > BYTE_W/2) || (ones_in == BYTE_W/2 && !pix[0]);
        qm[0]    = pix[0];
        for (int i = 1; i < BYTE_W; i++) begin
            qm[i] = use_xnor ? ~(qm[i-1] ^ pix[i]) : (qm[i-1] ^ pix[i]);
        end
        qm[BYTE_W] = ~use_xnor;
    end

    // Purpose: choose inversion from the disparity and compute the new one
    always_comb begin
        int  ones_q;
        int  bal;
        int  dcur;
        int  dnew;
        ones_q = $countones(qm[BYTE_W-1:0]);
        bal    = 2 * ones_q - BYTE_W;
        dcur   = int'(disp);
        if (dcur == 0 || bal == 0) begin
            sym  = {~qm[BYTE_W], qm[BYTE_W],
                    qm[BYTE_W] ? qm[BYTE_W-1:0] : ~qm[BYTE_W-1:0]};
            dnew = qm[BYTE_W] ? dcur + bal : dcur - bal;
        end else if ((dcur > 0 && bal > 0) || (dcur < 0 && bal < 0)) begin
            sym  = {1'b1, qm[BYTE_W], ~qm[BYTE_W-1:0]};
            dnew = dcur + 2 * int'(qm[BYTE_W]) - bal;
        end else begin
            sym  = {1'b0, qm[BYTE_W], qm[BYTE_W-1:0]};
            dnew = dcur - 2 * int'(!qm[BYTE_W]) + bal;
        end
        disp_nxt = DISP_W'(dnew);
    end

    // Purpose: hold disparity across video, clear it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       disp <= '0;
        else if (active)  disp <= disp_nxt;
        else              disp <= '0;
    end

    // R4
    // Any non-video beat leaves the disparity at zero
    disp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (disp == '0));

    // R3
    // Ones minus zeros over a byte is always even
    disp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp[0] == 1'b0);

endmodule

// File: rtl/lane_blank_coder.sv
// Symbols for all non-video beats: control codes, preamble guard,
// island guard and TERC4 payload. CHANNEL picks the per-lane guard values.
module lane_blank_coder
    import hdmi_lane_pkg::*;
#(
    parameter int CHANNEL = 0
) (
    input  lane_kind_e          kind,
    input  logic [NIB_W-1:0]    nib,
    input  logic [CTL_W-1:0]    ctl,
    output logic [SYM_W-1:0]    sym
);

    logic [SYM_W-1:0] vguard;
    logic [SYM_W-1:0] iguard;

    if (CHANNEL == 0) begin : g_lane0
        assign vguard = GUARD_A;
        assign iguard = terc4_code({2'b11, ctl});
    end else if (CHANNEL == 1) begin : g_lane1
        assign vguard = GUARD_B;
        assign iguard = GUARD_B;
    end else begin : g_lane2
        assign vguard = GUARD_A;
        assign iguard = GUARD_B;
    end

    // Purpose: select the symbol for the beat's kind
    always_comb begin
        case (kind)
            K_VGUARD: sym = vguard;
            K_IGUARD: sym = iguard;
            K_IPAY:   sym = terc4_code(nib);
            default:  sym = ctrl_code(ctl);
        endcase
    end

endmodule

// File: rtl/hdmi_lane_encoder.sv
// One HDMI TMDS lane: resolves enable priority, classifies each beat with
// a GUARD_LEN-deep lookahead, codes it and registers the symbol.
// Assumes CHANNEL is 0, 1 or 2; both enables high is treated as video.
module hdmi_lane_encoder
    import hdmi_lane_pkg::*;
#(
    parameter int CHANNEL   = 0,
    parameter int GUARD_LEN = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vid_en,
    input  logic        aux_en,
    input  logic [7:0]  pix,
    input  logic [3:0]  nib,
    input  logic [1:0]  ctl,
    output logic [9:0]  sym
);

    lane_beat_t         intake;
    lane_beat_t         cur;
    lane_kind_e         kind;
    logic [SYM_W-1:0]   vid_sym;
    logic [SYM_W-1:0]   blank_sym;
    logic [SYM_W-1:0]   sym_q;

    assign intake = '{vid: vid_en, isl: aux_en & ~vid_en,
                      pix: pix, nib: nib, ctl: ctl};

    lane_period_tracker #(.GUARD_LEN(GUARD_LEN)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_in  (intake),
        .beat_cur (cur),
        .kind     (kind)
    );

    tmds_video_path u_video (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (kind == K_VIDEO),
        .pix    (cur.pix),
        .sym    (vid_sym)
    );

    lane_blank_coder #(.CHANNEL(CHANNEL)) u_blank (
        .kind (kind),
        .nib  (cur.nib),
        .ctl  (cur.ctl),
        .sym  (blank_sym)
    );

    // Purpose: register the lane symbol
    always_ff @(posedge clk) begin
        if (!rst_n)                 sym_q <= ctrl_code(2'b00);
        else if (kind == K_VIDEO)   sym_q <= vid_sym;
        else                        sym_q <= blank_sym;
    end

    assign sym = sym_q;

endmodule

// File: tb/hdmi_lane_encoder_test.sv
`timescale 1ns/1ps
module hdmi_lane_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_en = 1'b0;
    logic       aux_en = 1'b0;
    logic [7:0] pix = '0;
    logic [3:0] nib = '0;
    logic [1:0] ctl = '0;
    logic [9:0] sym0;
    logic [9:0] sym1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hdmi_lane_encoder #(.CHANNEL(0)) uut (
        .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .aux_en(aux_en),
        .pix(pix), .nib(nib), .ctl(ctl), .sym(sym0));

    hdmi_lane_encoder #(.CHANNEL(1)) uut_c1 (
        .clk(clk), .rst_n(rst_n), .vid_en(vid_en), .aux_en(aux_en),
        .pix(pix), .nib(nib), .ctl(ctl), .sym(sym1));

    localparam logic [9:0] T4 [16] = '{
        10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
        10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
        10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
        10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};
    localparam logic [9:0] CT [4] = '{
        10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011};

    localparam int MAXN = 64;
    logic       sv [MAXN];
    logic       sa [MAXN];
    logic [7:0] sp [MAXN];
    logic [3:0] sn [MAXN];
    logic [1:0] sc [MAXN];
    int         slen;
    logic [9:0] e0 [MAXN];
    logic [9:0] e1 [MAXN];
    string      etag [MAXN];

    task automatic check(input string tag, input string what,
                         input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
        end
    endtask

    function automatic bit fv(int i);
        if (i < 0 || i >= slen) return 1'b0;
        return sv[i];
    endfunction
    function automatic bit fi(int i);
        if (i < 0 || i >= slen) return 1'b0;
        return sa[i] & ~sv[i];
    endfunction
    function automatic bit fc(int i);
        return !fv(i) && !fi(i);
    endfunction

    // Reference TMDS coder from the requirement text
    task automatic ref_tmds(input logic [7:0] d, input int cin,
                            output logic [9:0] q, output int cout);
        logic [8:0] m;
        int n1;
        int diff;
        bit xn;
        n1 = 0;
        for (int i = 0; i < 8; i++) n1 += int'(d[i]);
        xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
        m[0] = d[0];
        for (int i = 1; i < 8; i++) m[i] = xn ? !(m[i-1] ^ d[i]) : (m[i-1] ^ d[i]);
        m[8] = !xn;
        n1 = 0;
        for (int i = 0; i < 8; i++) n1 += int'(m[i]);
        diff = n1 - (8 - n1);
        if (cin == 0 || diff == 0) begin
            q = {!m[8], m[8], m[8] ? m[7:0] : ~m[7:0]};
            cout = m[8] ? cin + diff : cin - diff;
        end else if ((cin > 0) == (diff > 0)) begin
            q = {1'b1, m[8], ~m[7:0]};
            cout = cin + (m[8] ? 2 : 0) - diff;
        end else begin
            q = {1'b0, m[8], m[7:0]};
            cout = cin - (m[8] ? 0 : 2) + diff;
        end
    endtask

    function automatic logic [7:0] decode(input logic [9:0] q);
        logic [7:0] b;
        logic [7:0] d;
        b = q[9] ? ~q[7:0] : q[7:0];
        d[0] = b[0];
        for (int i = 1; i < 8; i++) d[i] = q[8] ? (b[i] ^ b[i-1]) : !(b[i] ^ b[i-1]);
        return d;
    endfunction

    task automatic build_expect();
        int cnt = 0;
        for (int i = 0; i < slen; i++) begin
            if (fv(i)) begin
                logic [9:0] q;
                int nc;
                ref_tmds(sp[i], cnt, q, nc);
                cnt = nc;
                e0[i] = q; e1[i] = q;
                etag[i] = sa[i] ? "R8" : (fv(i-1) ? "R3" : "R4");
            end else begin
                cnt = 0;
                if (fi(i)) begin
                    if (!fi(i-1) || !fi(i-2) || !fi(i+1) || !fi(i+2)) begin
                        e0[i] = T4[{2'b11, sc[i]}]; e1[i] = 10'b0100110011;
                        etag[i] = "R6";
                    end else begin
                        e0[i] = T4[sn[i]]; e1[i] = T4[sn[i]];
                        etag[i] = "R7";
                    end
                end else if (fv(i+1) || (fc(i+1) && fv(i+2))) begin
                    e0[i] = 10'b1011001100; e1[i] = 10'b0100110011;
                    etag[i] = "R5";
                end else begin
                    e0[i] = CT[sc[i]]; e1[i] = CT[sc[i]];
                    etag[i] = "R2";
                end
            end
        end
    endtask

    task automatic put(input bit v, input bit a, input logic [7:0] p,
                       input logic [3:0] n, input logic [1:0] c);
        sv[slen] = v; sa[slen] = a; sp[slen] = p; sn[slen] = n; sc[slen] = c;
        slen++;
    endtask

    task automatic idle_beats(input int n, input logic [1:0] c);
        for (int k = 0; k < n; k++) put(1'b0, 1'b0, 8'h00, 4'h0, c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vid_en = 1'b0; aux_en = 1'b0; pix = '0; nib = '0; ctl = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive the stored stream after a reset and compare with the model
    task automatic run_stream(input string name);
        build_expect();
        do_reset();
        for (int j = 0; j < slen + 2; j++) begin
            if (j < slen) begin
                vid_en = sv[j]; aux_en = sa[j]; pix = sp[j]; nib = sn[j]; ctl = sc[j];
            end else begin
                vid_en = 1'b0; aux_en = 1'b0; pix = '0; nib = '0; ctl = '0;
            end
            @(negedge clk);
            if (j >= 2) begin
                int i = j - 2;
                check(etag[i], $sformatf("%s lane0 beat %0d", name, i), sym0, e0[i]);
                check(etag[i], $sformatf("%s lane1 beat %0d", name, i), sym1, e1[i]);
                if (fv(i))
                    check("R3", $sformatf("%s decode beat %0d", name, i),
                          {2'b00, decode(sym0)}, {2'b00, sp[i]});
            end
        end
    endtask

    // R1: reset value regardless of active inputs
    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0; vid_en = 1'b1; aux_en = 1'b1; pix = 8'hA5; nib = 4'h9; ctl = 2'b11;
        repeat (3) @(negedge clk);
        check("R1", "reset lane0", sym0, 10'b1101010100);
        check("R1", "reset lane1", sym1, 10'b1101010100);
        rst_n = 1'b1; vid_en = 1'b0; aux_en = 1'b0; ctl = 2'b00;
    endtask

    // R9: two edges after capture, output still old; third shows new
    task automatic test_latency();
        do_reset();
        repeat (3) @(negedge clk);
        ctl = 2'b11;
        @(negedge clk);
        check("R9", "after capture edge", sym0, 10'b1101010100);
        @(negedge clk);
        check("R9", "after first edge", sym0, 10'b1101010100);
        @(negedge clk);
        check("R9", "after second edge", sym0, 10'b1010101011);
        ctl = 2'b00;
    endtask

    // R2: all control codes
    task automatic test_control();
        slen = 0;
        put(0, 0, 0, 0, 2'b00); put(0, 0, 0, 0, 2'b01);
        put(0, 0, 0, 0, 2'b10); put(0, 0, 0, 0, 2'b11);
        put(0, 0, 0, 0, 2'b11); put(0, 0, 0, 0, 2'b10);
        put(0, 0, 0, 0, 2'b01); put(0, 0, 0, 0, 2'b00);
        run_stream("control");
    endtask

    // R3 R4 R5: video runs with disparity, preamble, restart after blanking
    task automatic test_video();
        logic [7:0] bytes [14] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h01,
                                   8'h80, 8'h7E, 8'h10, 8'hE7, 8'h33, 8'hC3, 8'h99};
        slen = 0;
        idle_beats(3, 2'b01);
        for (int k = 0; k < 14; k++) put(1, 0, bytes[k], 0, 2'b01);
        idle_beats(3, 2'b10);
        for (int k = 0; k < 6; k++) put(1, 0, bytes[13-k], 0, 2'b10);
        idle_beats(2, 2'b00);
        run_stream("video");
    endtask

    // R6 R7: long and short islands, island next to video
    task automatic test_island();
        slen = 0;
        idle_beats(3, 2'b10);
        for (int k = 0; k < 16; k++) put(0, 1, 0, 4'(k), 2'b11);
        idle_beats(2, 2'b00);
        for (int k = 0; k < 3; k++) put(0, 1, 0, 4'(k + 5), 2'b01);
        idle_beats(1, 2'b00);
        put(0, 1, 0, 4'hC, 2'b10);
        idle_beats(1, 2'b01);
        for (int k = 0; k < 4; k++) put(1, 0, 8'(8'h3C + k), 0, 2'b00);
        for (int k = 0; k < 5; k++) put(0, 1, 0, 4'(15 - k), 2'b00);
        idle_beats(2, 2'b11);
        run_stream("island");
    endtask

    // R8: both enables high behaves as video
    task automatic test_priority();
        slen = 0;
        idle_beats(3, 2'b00);
        put(1, 1, 8'h12, 4'h3, 2'b00); put(1, 1, 8'hFE, 4'h4, 2'b00);
        put(1, 1, 8'h81, 4'h5, 2'b00); put(1, 0, 8'h6D, 4'h6, 2'b00);
        for (int k = 0; k < 6; k++) put(0, 1, 0, 4'(k + 9), 2'b01);
        idle_beats(2, 2'b00);
        run_stream("priority");
    endtask

    initial begin
        test_reset();
        test_latency();
        test_control();
        test_video();
        test_island();
        test_priority();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule